// File: doc/BRIEF.md
# Cathode Cut-off Measurement Sequencer

This block times the automatic cut-off calibration of a picture tube's three cathodes. It receives digitised comparator flags: the vertical part of the sandcastle pulse, the horizontal line pulse, an optional vertical flyback pulse, a cathode-warm flag, a cut-off-loop-stable flag and a leakage-reset flag. It also receives a control bit that turns cut-off control off. From these it produces per-line strobes for the analog datapath: a leakage measurement window, one measurement pulse per colour channel, output blanking, output clamping, brightness disable, a white monitor pulse enable and a cut-off loop enable.

After the vertical interval, one burst of measurement lines runs. The first line measures leakage and each following line drives one channel's measurement pulse. A small phase controller covers tube warm-up: the outputs stay blanked and a monitor pulse is shown until the cathodes conduct. Cut-off control then settles, and only then is the picture released. All inputs are sampled once on the clock, and every strobe reflects the state after that sample.

Top module: `cutoff_meas_seq`

## Requirements
- R1: While the asynchronous reset is held, out_blank_o is 1 and every other output is 0.
- R2: A burst is armed by the first falling edge, within a vertical interval, of either sc_vert_i or flyback_i. A falling edge of the other signal later in the same interval has no effect. The interval begins at the rising edge of sc_vert_i.
- R3: A burst has NUM_CHAN+1 lines. Line 0 raises leak_meas_o, and line c+1 raises chan_meas_o[c], with bit 0 red, bit 1 green and bit 2 blue. These strobes appear only while cut-off control is active, and at most one of them is high at a time.
- R4: bright_dis_o is high from the rising edge of sc_vert_i until the later of two events: the end of sc_vert_i, or the end of the last burst line. This includes the wait between the trigger and the first line.
- R5: If flyback_i is never high during a vertical interval, no burst runs in it. In that case no measurement or clamp strobe appears, and bright_dis_o follows sc_vert_i alone.
- R6: When cutoff_off_i is 1, cutoff_en_o and all measurement strobes are 0, and out_clamp_o is high for each line of the burst instead.
- R7: In the warm-up phase, out_blank_o is constantly 1, cutoff_en_o is 0 and monitor_en_o equals bright_dis_o.
- R8: cath_warm_i in the warm-up phase moves the block to the settling phase. There, monitor_en_o is 0 and cutoff_en_o equals NOT cutoff_off_i, while out_blank_o stays 1.
- R9: loop_stable_i in the settling phase moves the block to the run phase, where out_blank_o equals bright_dis_o. loop_stable_i has no effect in any other phase.
- R10: leak_reset_i returns the block to the warm-up phase from any phase on the next clock.
- R11: The first burst line starts on the first rising edge of hline_i that is sampled at or after the trigger. A rising edge in the same clock as the trigger counts. A partly elapsed line is never counted, and each line lasts from one rising edge of hline_i to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_vert_i | input | 1 | Vertical component of the sandcastle pulse |
| hline_i | input | 1 | Horizontal line pulse |
| flyback_i | input | 1 | External vertical flyback pulse |
| cath_warm_i | input | 1 | Cathode current has passed the warm threshold |
| loop_stable_i | input | 1 | Cut-off loop reports stable levels |
| leak_reset_i | input | 1 | Leakage store requests a return to warm-up |
| cutoff_off_i | input | 1 | 1 = cut-off control off, clamp outputs instead |
| leak_meas_o | output | 1 | Leakage measurement line |
| chan_meas_o | output | NUM_CHAN | Per-channel measurement pulse |
| out_blank_o | output | 1 | Blank video outputs to ultra-black |
| out_clamp_o | output | 1 | Clamp outputs to fixed levels |
| bright_dis_o | output | 1 | Disable brightness adjust |
| monitor_en_o | output | 1 | Drive white monitor pulse |
| cutoff_en_o | output | 1 | Enable the cut-off control loop |

## Verification
A wrong trigger or line count shows up as a strobe that begins or ends on the wrong line boundary. The error is visible in the first line of the affected burst, one clock after the offending horizontal edge, because every output derives from state registered once after the inputs. A wrong phase shows at once on out_blank_o, monitor_en_o or cutoff_en_o, in the clock after the cath_warm_i, loop_stable_i or leak_reset_i sample. Sweeping sandcastle widths (including one whose trigger lands exactly on a line edge) against each flyback mode exposes arming and blanking errors within a single field.

// File: rtl/cutoff_meas_pkg.sv
package cutoff_meas_pkg;

  // Switch-on phases of the calibration controller
  typedef enum logic [1:0] {
    PH_RESET  = 2'd0,
    PH_WARM   = 2'd1,
    PH_SETTLE = 2'd2,
    PH_RUN    = 2'd3
  } phase_t;

endpackage

// File: rtl/cms_flag_reg.sv
// Samples the digitised comparator flags once per clock.
module cms_flag_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end

endmodule

// File: rtl/cms_burst_timer.sv
// Arms on the first trailing vertical edge and counts the measurement lines.
module cms_burst_timer #(
  parameter int LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sc_in,
  input  logic                 sc_q,
  input  logic                 fb_in,
  input  logic                 fb_q,
  input  logic                 ln_in,
  input  logic                 ln_q,
  output logic                 pend_o,
  output logic                 busy_o,
  output logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] idx_o
);

  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [LW-1:0] LAST = LW'(LINES - 1);

  logic sc_rise, sc_fall, fb_fall, ln_rise;
  logic trig, start;
  logic fired_q, fired_d;
  logic seen_q, seen_d;
  logic pend_q, pend_d;
  logic busy_q, busy_d;
  logic [LW-1:0] idx_q, idx_d;

  assign sc_rise = sc_in & ~sc_q;
  assign sc_fall = ~sc_in & sc_q;
  assign fb_fall = ~fb_in & fb_q;
  assign ln_rise = ln_in & ~ln_q;

  // first trailing edge of either vertical signal, only once per interval
  assign trig  = (sc_fall | fb_fall) & ~fired_q & seen_q & ~pend_q & ~busy_q;
  assign start = ln_rise & (pend_q | trig);

  always_comb begin
    fired_d = fired_q;
    if (trig)    fired_d = 1'b1;
    if (sc_rise) fired_d = 1'b0;

    seen_d = fb_in | (seen_q & ~sc_rise);

    pend_d = pend_q;
    if (start)     pend_d = 1'b0;
    else if (trig) pend_d = 1'b1;

    busy_d = busy_q;
    idx_d  = idx_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q && ln_rise) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      seen_q  <= 1'b0;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      fired_q <= fired_d;
      seen_q  <= seen_d;
      pend_q  <= pend_d;
      busy_q  <= busy_d;
      idx_q   <= idx_d;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/cms_phase_fsm.sv
// Two-step switch-on sequence: warm-up, settling, run.
module cms_phase_fsm
  import cutoff_meas_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   warm_i,
  input  logic   stable_i,
  input  logic   lrst_i,
  output phase_t phase_o
);

  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (lrst_i) begin
      phase_d = PH_WARM;
    end else begin
      case (phase_q)
        PH_RESET:  phase_d = PH_WARM;
        PH_WARM:   if (warm_i)   phase_d = PH_SETTLE;
        PH_SETTLE: if (stable_i) phase_d = PH_RUN;
        PH_RUN:    phase_d = PH_RUN;
        default:   phase_d = PH_WARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_RESET;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/cutoff_meas_seq.sv
module cutoff_meas_seq
  import cutoff_meas_pkg::*;
#(
  parameter int NUM_CHAN = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sc_vert_i,
  input  logic                hline_i,
  input  logic                flyback_i,
  input  logic                cath_warm_i,
  input  logic                loop_stable_i,
  input  logic                leak_reset_i,
  input  logic                cutoff_off_i,
  output logic                leak_meas_o,
  output logic [NUM_CHAN-1:0] chan_meas_o,
  output logic                out_blank_o,
  output logic                out_clamp_o,
  output logic                bright_dis_o,
  output logic                monitor_en_o,
  output logic                cutoff_en_o
);

  localparam int LINES = NUM_CHAN + 1;
  localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1;

  logic [2:0]    flag_d, flag_q;
  logic          pend, busy;
  logic [LW-1:0] idx;
  phase_t        phase;
  logic          vblank, cut_act;

  assign flag_d = {sc_vert_i, flyback_i, hline_i};

  cms_flag_reg #(.W(3)) flags_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (flag_d),
    .q_o   (flag_q)
  );

  cms_burst_timer #(.LINES(LINES)) burst_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sc_in  (sc_vert_i),
    .sc_q   (flag_q[2]),
    .fb_in  (flyback_i),
    .fb_q   (flag_q[1]),
    .ln_in  (hline_i),
    .ln_q   (flag_q[0]),
    .pend_o (pend),
    .busy_o (busy),
    .idx_o  (idx)
  );

  cms_phase_fsm phase_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_i   (cath_warm_i),
    .stable_i (loop_stable_i),
    .lrst_i   (leak_reset_i),
    .phase_o  (phase)
  );

  // vertical interval as seen by the outputs: sandcastle, wait, burst
  assign vblank  = flag_q[2] | pend | busy;
  assign cut_act = ((phase == PH_SETTLE) || (phase == PH_RUN)) && !cutoff_off_i;

  assign leak_meas_o = busy & (idx == '0) & cut_act;

  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      assign chan_meas_o[c] = busy & (idx == LW'(c + 1)) & cut_act;
    end
  endgenerate

  assign out_clamp_o  = busy & cutoff_off_i & (phase != PH_RESET);
  assign bright_dis_o = vblank;
  assign out_blank_o  = (phase != PH_RUN) | vblank;
  assign monitor_en_o = (phase == PH_WARM) & vblank;
  assign cutoff_en_o  = cut_act;

endmodule

// File: rtl/cutoff_meas_seq_chk.sv
module cutoff_meas_seq_chk #(
  parameter int NUM_CHAN = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                leak_reset_i,
  input logic                cutoff_off_i,
  input logic                leak_meas_o,
  input logic [NUM_CHAN-1:0] chan_meas_o,
  input logic                out_blank_o,
  input logic                out_clamp_o,
  input logic                bright_dis_o,
  input logic                monitor_en_o,
  input logic                cutoff_en_o
);

  // R3
  meas_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({leak_meas_o, chan_meas_o}));

  // R6
  coff_no_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cutoff_off_i |-> (!leak_meas_o && (chan_meas_o == '0) && !cutoff_en_o));

  // R6
  clamp_needs_coff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_clamp_o |-> cutoff_off_i);

  // R7
  monitor_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    monitor_en_o |-> (out_blank_o && !cutoff_en_o));

  // R4
  meas_in_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_meas_o || (chan_meas_o != '0) || out_clamp_o) |-> bright_dis_o);

  // R9
  unblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_blank_o |-> (!bright_dis_o && !monitor_en_o));

  // R10
  leak_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leak_reset_i |=> (!cutoff_en_o && out_blank_o));

endmodule

bind cutoff_meas_seq cutoff_meas_seq_chk #(.NUM_CHAN(NUM_CHAN)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .leak_reset_i (leak_reset_i),
  .cutoff_off_i (cutoff_off_i),
  .leak_meas_o  (leak_meas_o),
  .chan_meas_o  (chan_meas_o),
  .out_blank_o  (out_blank_o),
  .out_clamp_o  (out_clamp_o),
  .bright_dis_o (bright_dis_o),
  .monitor_en_o (monitor_en_o),
  .cutoff_en_o  (cutoff_en_o)
);

// File: tb/cutoff_meas_seq_tb_top.sv
module cutoff_meas_seq_tb_top;

  localparam int NCH = 3;
  localparam int NL  = NCH + 1;
  localparam int P   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic sc = 1'b0, hl = 1'b0, fb = 1'b1, cw = 1'b0, ls = 1'b0, lr = 1'b0, co = 1'b0;
  logic           leak, blank, clamp, bdis, mon, cen;
  logic [NCH-1:0] chan;

  cutoff_meas_seq #(.NUM_CHAN(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sc_vert_i(sc), .hline_i(hl), .flyback_i(fb),
    .cath_warm_i(cw), .loop_stable_i(ls), .leak_reset_i(lr), .cutoff_off_i(co),
    .leak_meas_o(leak), .chan_meas_o(chan), .out_blank_o(blank), .out_clamp_o(clamp),
    .bright_dis_o(bdis), .monitor_en_o(mon), .cutoff_en_o(cen)
  );

  int    checks = 0, errors = 0, tick = 0, exp_ph = 0;
  bit    chk_en = 0, done = 0, valid = 0;
  int    sc_a = 0, sc_b = 0, fb_mode = 0, fb_r = 0, fb_f = 0;
  bit    coff_l = 0, warm_l = 0, stab_l = 0, lrst_l = 0;
  string ftag = "R1";

  task automatic chk(string sig, string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d tick=%0d", req, ftag, sig, act, exp, tick);
    end
  endtask

  // fb modes: 0 always high, 1 pulse ending before sc, 2 pulse ending after sc, 3 stuck low
  function automatic int fb_at(int t);
    case (fb_mode)
      0:       return 1;
      3:       return 0;
      default: return (t >= fb_r && t < fb_f) ? 1 : 0;
    endcase
  endfunction

  function automatic int trig_time();
    if (!valid || fb_mode == 3) return -1;
    if (fb_mode == 0)           return sc_b;
    return (fb_f < sc_b) ? fb_f : sc_b;
  endfunction

  task automatic check_cycle(int t);
    int trg, l0, k;
    bit busy, pb, vbl, act;
    trg = trig_time();
    busy = 0; pb = 0; k = 0;
    if (trg >= 0) begin
      l0   = ((trg + P - 1) / P) * P;           // R11 first full line
      busy = (t >= l0) && (t < l0 + NL * P);
      pb   = (t >= trg) && (t < l0 + NL * P);
      if (busy) k = (t - l0) / P;
    end
    vbl = ((t >= sc_a) && (t < sc_b)) || pb;
    act = (exp_ph >= 2) && !co;
    chk("leak", "R3", int'(leak), int'(busy && k == 0 && act));
    for (int c = 0; c < NCH; c++)
      chk("chan", "R3", int'(chan[c]), int'(busy && k == c + 1 && act));
    chk("clamp", "R6", int'(clamp), int'(busy && co && exp_ph != 0));
    chk("bright_dis", "R4", int'(bdis), int'(vbl));
    chk("monitor", "R7", int'(mon), int'(exp_ph == 1 && vbl));
    chk("cutoff_en", "R8", int'(cen), int'(act));
    chk("blank", "R9", int'(blank), int'(exp_ph != 3 || vbl));
  endtask

  // input driver and per-cycle checker, away from the active edge
  always @(negedge clk) begin
    if (!rst_n)  exp_ph = 0;
    else if (lr) exp_ph = 1;                    // R10
    else begin
      case (exp_ph)
        0: exp_ph = 1;
        1: if (cw) exp_ph = 2;
        2: if (ls) exp_ph = 3;
        default: ;
      endcase
    end
    if (chk_en && !done) check_cycle(tick);
    tick++;
    hl = ((tick % P) < 2);
    sc = (tick >= sc_a) && (tick < sc_b);
    fb = fb_at(tick) != 0;
    cw = warm_l; ls = stab_l; lr = lrst_l; co = coff_l;
  end

  task automatic run_field(string tag, int len, int mode, bit coff);
    int base, fend;
    @(posedge clk);
    ftag = tag; coff_l = coff;
    base = ((tick / P) + 2) * P;
    sc_a = base + 3; sc_b = sc_a + len;
    fb_mode = mode; fb_r = sc_a + 4;
    fb_f = (mode == 1) ? sc_a + 10 : sc_b + 25;
    valid = 1;
    fend = ((mode == 2) ? fb_f : sc_b) + (NL + 1) * P + 10;
    while (tick < fend) @(posedge clk);
  endtask

  // sel: 0 warm flag, 1 stable flag, 2 leakage reset
  task automatic pulse(int sel);
    @(posedge clk);
    if (sel == 0) warm_l = 1; else if (sel == 1) stab_l = 1; else lrst_l = 1;
    repeat (3) @(posedge clk);
    warm_l = 0; stab_l = 0; lrst_l = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int lens[4] = '{30, 37, 41, 58};
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("blank", "R1", int'(blank), 1);
    chk("leak", "R1", int'(leak), 0);
    chk("chan", "R1", int'(chan), 0);
    chk("clamp", "R1", int'(clamp), 0);
    chk("bright_dis", "R1", int'(bdis), 0);
    chk("monitor", "R1", int'(mon), 0);
    chk("cutoff_en", "R1", int'(cen), 0);
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    chk_en = 1;

    run_field("R7", 37, 0, 0);
    run_field("R7", 45, 1, 0);
    pulse(1);                                   // R9 stable ignored in warm-up
    run_field("R7", 33, 2, 0);
    run_field("R7", 40, 0, 1);
    pulse(0);                                   // R8 warm -> settling
    run_field("R8", 37, 0, 0);
    run_field("R8", 41, 3, 0);
    pulse(1);                                   // R9 settling -> run
    for (int cf = 0; cf < 2; cf++)
      for (int li = 0; li < 4; li++)
        for (int m = 0; m < 4; m++) begin
          string tg;
          if (cf == 1)                 tg = "R6";
          else if (m == 3)             tg = "R5";
          else if (m != 0)             tg = "R2";
          else if (lens[li] == 37)     tg = "R11";
          else                         tg = "R4";
          run_field(tg, lens[li], m, cf[0]);
        end
    pulse(0);                                   // warm flag ignored in run
    run_field("R9", 30, 0, 0);
    pulse(2);                                   // R10 back to warm-up
    run_field("R10", 37, 1, 0);
    pulse(0);
    run_field("R6", 41, 0, 1);
    run_field("R8", 30, 2, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired tick=%0d", tick);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule